// File: doc/BRIEF.md
# UART Register Access Gating

This block is the host-facing register file of a 16550-style UART. A narrow host bus (3-bit address, write and read strobes, byte-wide data) reaches the line control, divisor, enhanced-feature and FIFO control registers. Several registers share one address, and the one that answers depends on the current line control value. While the divisor-access bit is set, addresses 0, 1 and 7 reach the divisor registers. A dedicated line control key value turns address 2 into the enhanced-feature register.

The outputs drive the rest of the UART. They are the frame format fields, the FIFO enable, single-cycle FIFO clear pulses, a transmit push strobe with its byte, and the integer and fractional divisors for the baud generator. The FIFOs, the serial engine and the interrupts are outside this block.

Top module: `uart_reg_gate`

## Requirements
- R1: After reset, line control, the enhanced-feature register, the FIFO enable, the 16-bit divisor, the fractional divisor, the read data and all strobes are zero.
- R2: Address 3 always reaches line control. A written byte reads back unchanged. Bits [1:0] drive word_len_o, bit 2 drives two_stop_o, bit 3 drives parity_en_o, bit 4 drives parity_even_o, bit 6 drives break_o and bit 7 drives dlab_o.
- R3: With dlab_o high, a write to address 0 sets divisor bits [7:0], a write to address 1 sets divisor bits [15:8], and neither write produces a transmit push.
- R4: With dlab_o low, a write to address 0 raises tx_push_o for exactly one cycle, in the cycle after the write, with the byte on tx_data_o. The divisor is unchanged.
- R5: While line control holds 0xBF, address 2 reaches the enhanced-feature register for both writes and reads. The write neither changes the FIFO enable nor clears a FIFO. Bit 4 of that register drives enh_en_o.
- R6: While line control holds any other value, a write to address 2 reaches FIFO control and leaves the enhanced-feature register unchanged. Bit 0 is stored as fifo_en_o. Bit 1 gives a one-cycle rx_fifo_rst_o and bit 2 gives a one-cycle tx_fifo_rst_o, each in the cycle after the write. Neither clear bit is stored. A read of address 2 in this state returns 0.
- R7: A write to address 7 sets the 6-bit fractional divisor from data bits [5:0] only when dlab_o and enh_en_o are both high. Otherwise the write is ignored.
- R8: Read data appears on rdata_o in the cycle after a read strobe and holds until the next read. Addresses 0 and 1 read back the divisor bytes when dlab_o is high, and address 7 reads back the fractional divisor when it is reachable. Unmapped or write-only targets read 0.
- R9: With dlab_o low, a write to address 1 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| word_len_o | output | 2 | Word length code |
| two_stop_o | output | 1 | Two stop bits select |
| parity_en_o | output | 1 | Parity enable |
| parity_even_o | output | 1 | Even parity select |
| break_o | output | 1 | Break control |
| dlab_o | output | 1 | Divisor access enabled |
| enh_en_o | output | 1 | Enhanced functions enabled |
| fifo_en_o | output | 1 | FIFO enable |
| rx_fifo_rst_o | output | 1 | Receive FIFO clear pulse |
| tx_fifo_rst_o | output | 1 | Transmit FIFO clear pulse |
| tx_push_o | output | 1 | Transmit push strobe |
| tx_data_o | output | 8 | Byte pushed to transmit |
| div_o | output | 16 | Integer baud divisor |
| div_frac_o | output | 6 | Fractional divisor in 1/64 units |

## Verification
The hardest state to reach is a write to address 7 that actually lands in the fractional divisor. It needs three conditions in order: line control set to the key value, the enhanced-feature enable bit set, and line control then changed to a value that keeps divisor access. The stimulus follows the full configuration order: key, enable, frame format with divisor access, the three divisor writes, and a return to normal mode. It then clears the enable again under the key and tries address 7 once more. That write must be ignored, which shows the gate depends on the stored enable and not only on the divisor-access bit.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_THR,
    SEL_DLL,
    SEL_DLH,
    SEL_FCR,
    SEL_EFR,
    SEL_LCR,
    SEL_DLF
  } reg_sel_e;

  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_HIGH = 3'd1;
  localparam logic [2:0] ADR_CTRL = 3'd2;
  localparam logic [2:0] ADR_LINE = 3'd3;
  localparam logic [2:0] ADR_FRAC = 3'd7;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
(
  input  logic [2:0] addr_i,
  input  logic       dlab_i,
  input  logic       efr_open_i,
  input  logic       frac_en_i,
  output reg_sel_e   sel_o
);
  always_comb begin
    unique case (addr_i)
      ADR_DATA: sel_o = dlab_i ? SEL_DLL : SEL_THR;
      ADR_HIGH: sel_o = dlab_i ? SEL_DLH : SEL_NONE;
      ADR_CTRL: sel_o = efr_open_i ? SEL_EFR : SEL_FCR;
      ADR_LINE: sel_o = SEL_LCR;
      ADR_FRAC: sel_o = (dlab_i && frac_en_i) ? SEL_DLF : SEL_NONE;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_reg_div.sv
module uart_reg_div #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 6,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic              we_frac_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      frac_o <= '0;
    end else begin
      if (we_lo_i)   div_o[DATA_W-1:0]     <= wdata_i;
      if (we_hi_i)   div_o[DIV_W-1:DATA_W] <= wdata_i;
      if (we_frac_i) frac_o                <= wdata_i[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/uart_reg_fifo_ctl.sv
module uart_reg_fifo_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] ctl_i,
  output logic       fifo_en_o,
  output logic       rx_rst_o,
  output logic       tx_rst_o
);
  // clear bits are pulses, never held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_o <= 1'b0;
      rx_rst_o  <= 1'b0;
      tx_rst_o  <= 1'b0;
    end else begin
      rx_rst_o <= we_i & ctl_i[1];
      tx_rst_o <= we_i & ctl_i[2];
      if (we_i) fifo_en_o <= ctl_i[0];
    end
  end
endmodule

// File: rtl/uart_reg_gate.sv
module uart_reg_gate
  import uart_reg_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          FRAC_W  = 6,
  parameter logic [7:0]  EFR_KEY = 8'hBF,
  parameter int          ENH_BIT = 4,
  localparam int         DIV_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        word_len_o,
  output logic              two_stop_o,
  output logic              parity_en_o,
  output logic              parity_even_o,
  output logic              break_o,
  output logic              dlab_o,
  output logic              enh_en_o,
  output logic              fifo_en_o,
  output logic              rx_fifo_rst_o,
  output logic              tx_fifo_rst_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] div_frac_o
);
  logic [DATA_W-1:0] lcr_q;
  logic [DATA_W-1:0] efr_q;
  reg_sel_e          sel;
  logic              efr_open;

  assign efr_open = (lcr_q == EFR_KEY);

  uart_reg_decode u_dec (
    .addr_i     (addr_i),
    .dlab_i     (lcr_q[7]),
    .efr_open_i (efr_open),
    .frac_en_i  (efr_q[ENH_BIT]),
    .sel_o      (sel)
  );

  uart_reg_div #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_lo_i   (wr_i && sel == SEL_DLL),
    .we_hi_i   (wr_i && sel == SEL_DLH),
    .we_frac_i (wr_i && sel == SEL_DLF),
    .wdata_i   (wdata_i),
    .div_o     (div_o),
    .frac_o    (div_frac_o)
  );

  uart_reg_fifo_ctl u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_i && sel == SEL_FCR),
    .ctl_i     (wdata_i[2:0]),
    .fifo_en_o (fifo_en_o),
    .rx_rst_o  (rx_fifo_rst_o),
    .tx_rst_o  (tx_fifo_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q     <= '0;
      efr_q     <= '0;
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      if (wr_i && sel == SEL_LCR) lcr_q <= wdata_i;
      if (wr_i && sel == SEL_EFR) efr_q <= wdata_i;
      tx_push_o <= wr_i && sel == SEL_THR;
      if (wr_i && sel == SEL_THR) tx_data_o <= wdata_i;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_DLL: rd_mux = div_o[DATA_W-1:0];
      SEL_DLH: rd_mux = div_o[DIV_W-1:DATA_W];
      SEL_EFR: rd_mux = efr_q;
      SEL_LCR: rd_mux = lcr_q;
      SEL_DLF: rd_mux = DATA_W'(div_frac_o);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign word_len_o    = lcr_q[1:0];
  assign two_stop_o    = lcr_q[2];
  assign parity_en_o   = lcr_q[3];
  assign parity_even_o = lcr_q[4];
  assign break_o       = lcr_q[6];
  assign dlab_o        = lcr_q[7];
  assign enh_en_o      = efr_q[ENH_BIT];
endmodule

// File: rtl/uart_reg_gate_chk.sv
module uart_reg_gate_chk #(
  parameter int         DATA_W  = 8,
  parameter int         FRAC_W  = 6,
  parameter logic [7:0] EFR_KEY = 8'hBF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] lcr_q,
  input logic              dlab_o,
  input logic              enh_en_o,
  input logic              fifo_en_o,
  input logic              rx_fifo_rst_o,
  input logic              tx_fifo_rst_o,
  input logic              tx_push_o,
  input logic [2*DATA_W-1:0] div_o,
  input logic [FRAC_W-1:0] div_frac_o
);
  p_push_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(wr_i && addr_i == 3'd0 && !dlab_o));

  p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && dlab_o && addr_i <= 3'd1) |=> $stable(div_o));

  p_efr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 3'd2 && lcr_q == EFR_KEY) |=> $stable(enh_en_o));

  p_clr_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fifo_rst_o || tx_fifo_rst_o) |-> $past(wr_i && addr_i == 3'd2 && lcr_q != EFR_KEY));

  p_fifo_en_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 3'd2 && lcr_q != EFR_KEY) |=> $stable(fifo_en_o));

  p_frac_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd7 && !(dlab_o && enh_en_o)) |=> $stable(div_frac_o));
endmodule

bind uart_reg_gate uart_reg_gate_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .EFR_KEY(EFR_KEY)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .lcr_q         (lcr_q),
  .dlab_o        (dlab_o),
  .enh_en_o      (enh_en_o),
  .fifo_en_o     (fifo_en_o),
  .rx_fifo_rst_o (rx_fifo_rst_o),
  .tx_fifo_rst_o (tx_fifo_rst_o),
  .tx_push_o     (tx_push_o),
  .div_o         (div_o),
  .div_frac_o    (div_frac_o)
);

// File: tb/uart_reg_gate_test.sv
`timescale 1ns/1ps
module uart_reg_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tx_data;
  logic [1:0] word_len;
  logic       two_stop, par_en, par_even, brk, dlab, enh_en, fifo_en;
  logic       rx_clr, tx_clr, tx_push;
  logic [15:0] div;
  logic [5:0]  frac;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_reg_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .word_len_o(word_len),
    .two_stop_o(two_stop), .parity_en_o(par_en), .parity_even_o(par_even),
    .break_o(brk), .dlab_o(dlab), .enh_en_o(enh_en), .fifo_en_o(fifo_en),
    .rx_fifo_rst_o(rx_clr), .tx_fifo_rst_o(tx_clr), .tx_push_o(tx_push),
    .tx_data_o(tx_data), .div_o(div), .div_frac_o(frac)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns one negedge later
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic push_exp(input logic [7:0] d);
    exp_q.push_back(d);
    bus_wr(3'd0, d);
  endtask

  // scoreboard monitor for transmit pushes (R4, R3)
  initial forever begin
    @(negedge clk);
    if (rst_n && tx_push) begin
      if (exp_q.size() == 0) check("R3 unexpected push", 32'(tx_data), 32'hFFFF_FFFF);
      else check("R4 push data", 32'(tx_data), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 div", 32'(div), 0);
    check("R1 frac", 32'(frac), 0);
    check("R1 cfg", {27'd0, dlab, enh_en, fifo_en, rx_clr | tx_clr, tx_push}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(3'd3, 8'h00, "R1 lcr read");

    bus_wr(3'd3, 8'hBF);
    bus_rd(3'd3, 8'hBF, "R2 lcr readback");
    check("R2 dlab", 32'(dlab), 1);
    bus_wr(3'd2, 8'h10);
    check("R5 no clear", 32'({rx_clr, tx_clr, fifo_en}), 0);
    check("R5 enh_en", 32'(enh_en), 1);
    bus_rd(3'd2, 8'h10, "R5 efr read");

    bus_wr(3'd3, 8'h93);
    check("R2 fields", 32'({word_len, two_stop, par_en, par_even, brk, dlab}), 32'b11_0_0_1_0_1);
    bus_rd(3'd2, 8'h00, "R6 fcr reads zero");
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd0, 8'h9C);
    bus_wr(3'd7, 8'h10);
    check("R3 divisor", 32'(div), 32'h009C);
    check("R7 frac", 32'(frac), 32'h10);
    bus_rd(3'd0, 8'h9C, "R8 dll read");
    bus_rd(3'd1, 8'h00, "R8 dlh read");
    bus_rd(3'd7, 8'h10, "R8 dlf read");

    bus_wr(3'd3, 8'h13);
    check("R2 normal", 32'({word_len, par_en, par_even, dlab}), 32'b11_0_1_0);
    bus_wr(3'd2, 8'h06);
    check("R6 clear pulses", 32'({rx_clr, tx_clr}), 32'b11);
    check("R6 efr kept", 32'(enh_en), 1);
    @(negedge clk);
    check("R6 pulses drop", 32'({rx_clr, tx_clr, fifo_en}), 0);
    bus_wr(3'd2, 8'h01);
    check("R6 fifo_en", 32'({rx_clr, tx_clr, fifo_en}), 32'b001);

    push_exp(8'hAA);
    push_exp(8'h55);
    @(negedge clk);
    check("R4 single cycle", 32'(tx_push), 0);
    check("R4 divisor kept", 32'(div), 32'h009C);

    bus_wr(3'd1, 8'h77);
    check("R9 divisor kept", 32'(div), 32'h009C);
    bus_rd(3'd1, 8'h00, "R9 addr1 reads zero");
    bus_wr(3'd7, 8'h3F);
    check("R7 no dlab", 32'(frac), 32'h10);

    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd2, 8'h00);
    check("R5 enh cleared", 32'(enh_en), 0);
    check("R5 fifo_en kept", 32'(fifo_en), 1);
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd7, 8'h05);
    check("R7 no enh", 32'(frac), 32'h10);
    bus_rd(3'd7, 8'h00, "R8 dlf hidden");
    bus_wr(3'd0, 8'h01);
    check("R3 dll write", 32'(div), 32'h0001);
    bus_rd(3'd5, 8'h00, "R8 unmapped");
    repeat (2) @(negedge clk);
    check("R4 queue drained", 32'(exp_q.size()), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule